// File: doc/BRIEF.md
# Paced Line Output Controller

This block sits between a processor and a slow character device. The processor fills an internal line buffer, one character per cycle, at full clock rate. It then pulses a start command that carries the number of characters to send and a pacing value. From then on the controller works on its own. It offers the characters to the device in address order, one at a time, and it never offers them faster than the pacing value allows. A character moves only when the device signals that it can take it. The processor is never stalled during this time.

When the device has accepted the final character, the controller raises a level interrupt. The interrupt stays high until the processor acknowledges it. While a line is being sent, the buffer and the command inputs are locked, so the line in flight cannot be altered. A start with a length of zero completes at once: it raises the interrupt and sends nothing.

Top module: `line_out_ctrl`

## Requirements
- R1: After reset, `busy`, `irq` and `dev_valid` are all low.
- R2: While idle, a write with `wr_en` high stores `wr_data` at buffer index `wr_addr`. Indices at or beyond DEPTH are dropped. A transfer of length L presents buffer indices 0, 1, ..., L-1 on `dev_data` in that order.
- R3: A `start` pulse taken while idle with a nonzero length raises `busy` in the next cycle, and `dev_valid` rises in that same cycle. A length greater than DEPTH is treated as DEPTH.
- R4: After each accepted character, `dev_valid` stays low for exactly `div_in` cycles, using the value latched at start. With `dev_ready` held high, consecutive characters are therefore accepted exactly `div_in`+1 cycles apart.
- R5: A character is accepted only in a cycle where both `dev_valid` and `dev_ready` are high. While `dev_valid` is high and `dev_ready` is low, `dev_valid` and `dev_data` hold their values.
- R6: While `busy` is high, buffer writes and `start` pulses have no effect on the characters sent or on the transfer length.
- R7: In the cycle after the last character is accepted, `irq` rises and `busy` falls. `irq` stays low at every point before that.
- R8: `irq` stays high until `irq_ack` is sampled high. `irq_ack` then clears `irq` in the next cycle.
- R9: If `irq_ack` arrives in the same cycle as a completion, the completion wins and `irq` is high in the next cycle.
- R10: A `start` taken while idle with length 0 sets `irq` in the next cycle. `busy` stays low and no character is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | AW | Buffer index to write |
| wr_data | input | DATA_W | Character to store |
| start | input | 1 | Begin sending a line |
| len_in | input | LEN_W | Number of characters to send, sampled with start |
| div_in | input | DIV_W | Idle cycles after each character, sampled with start |
| busy | output | 1 | A line is being sent |
| irq | output | 1 | Completion interrupt, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge |
| dev_data | output | DATA_W | Character offered to the device |
| dev_valid | output | 1 | dev_data is offered |
| dev_ready | input | 1 | Device can take a character |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both.

The first pair is the acknowledge of an interrupt and the completion that sets it again. The bench drives `irq_ack` in exactly the cycle in which it sees the final character being accepted. It then expects `irq` to be high one cycle later, not cleared.

The second pair is a buffer write or a new start pulse arriving while a line is still draining. The bench injects both after the first character has gone. It then judges the result by the characters that actually reach the device, their count, and the moment the interrupt rises.

// File: rtl/lo_pkg.sv
package lo_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } lo_state_e;

endpackage

// File: rtl/lo_linebuf.sv
module lo_linebuf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 80,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DATA_W-1:0] cells [DEPTH];
    logic              waddr_ok;
    logic              raddr_ok;

    assign waddr_ok = {1'b0, waddr} < LIMIT;
    assign raddr_ok = {1'b0, raddr} < LIMIT;

    always_ff @(posedge clk) begin
        if (we && waddr_ok) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = raddr_ok ? cells[raddr] : '0;

endmodule

// File: rtl/lo_pacer.sv
module lo_pacer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             fire,
    input  logic [DIV_W-1:0] gap_cycles,
    output logic             open
);

    logic [DIV_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (arm) begin
            gap_d = '0;
        end else if (fire) begin
            gap_d = gap_cycles;
        end else if (gap_q != '0) begin
            gap_d = gap_q - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_d;
        end
    end

    assign open = (gap_q == '0);

endmodule

// File: rtl/line_out_ctrl.sv
module line_out_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 80,
    parameter int DIV_W  = 8,
    parameter int AW     = $clog2(DEPTH),
    parameter int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [DIV_W-1:0]  div_in,
    output logic              busy,
    output logic              irq,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] dev_data,
    output logic              dev_valid,
    input  logic              dev_ready
);

    import lo_pkg::*;

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);

    typedef struct packed {
        lo_state_e        state;
        logic             irq;
        logic [AW-1:0]    idx;
        logic [AW-1:0]    last;
        logic [DIV_W-1:0] div;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             idle;
    logic             fire;
    logic             gap_open;
    logic [LEN_W-1:0] len_eff;
    logic [DIV_W-1:0] div_cfg;

    assign idle      = (ctl_q.state == ST_IDLE);
    assign dev_valid = (ctl_q.state == ST_SEND) && gap_open;
    assign fire      = dev_valid && dev_ready;
    assign len_eff   = (len_in > LEN_MAX) ? LEN_MAX : len_in;
    assign div_cfg   = ctl_q.div;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = ctl_q.irq && !irq_ack;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (len_eff == '0) begin
                        ctl_d.irq = 1'b1;
                    end else begin
                        ctl_d.state = ST_SEND;
                        ctl_d.idx   = '0;
                        ctl_d.last  = AW'(len_eff - LEN_W'(1));
                        ctl_d.div   = div_in;
                    end
                end
            end
            ST_SEND: begin
                if (fire) begin
                    if (ctl_q.idx == ctl_q.last) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.irq   = 1'b1;
                    end else begin
                        ctl_d.idx = ctl_q.idx + AW'(1);
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, irq: 1'b0, idx: '0, last: '0, div: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lo_linebuf #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) buf_i (
        .clk  (clk),
        .we   (wr_en && idle),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(ctl_q.idx),
        .rdata(dev_data)
    );

    lo_pacer #(
        .DIV_W(DIV_W)
    ) pace_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (start && idle),
        .fire      (fire),
        .gap_cycles(ctl_q.div),
        .open      (gap_open)
    );

    assign busy = !idle;
    assign irq  = ctl_q.irq;

endmodule

// File: rtl/line_out_ctrl_chk.sv
module line_out_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  len_in,
    input logic              busy,
    input logic              irq,
    input logic              irq_ack,
    input logic [DATA_W-1:0] dev_data,
    input logic              dev_valid,
    input logic              dev_ready,
    input logic [DIV_W-1:0]  div_cfg
);

    assert_valid_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> busy);

    assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_ready |=> dev_valid && $stable(dev_data));

    assert_gap_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && dev_ready && (div_cfg != '0) |=> !dev_valid);

    assert_start_goes_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (len_in != '0) |=> busy);

    assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && !busy && !start |=> !irq);

    assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (len_in == '0) |=> irq && !busy);

endmodule

bind line_out_ctrl line_out_ctrl_chk #(
    .DATA_W(DATA_W),
    .DIV_W (DIV_W),
    .LEN_W (LEN_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len_in   (len_in),
    .busy     (busy),
    .irq      (irq),
    .irq_ack  (irq_ack),
    .dev_data (dev_data),
    .dev_valid(dev_valid),
    .dev_ready(dev_ready),
    .div_cfg  (div_cfg)
);

// File: tb/line_out_ctrl_tb.sv
module line_out_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int AW = 3;
    localparam int LEN_W = 4;
    localparam int DIV_W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       start = 1'b0;
    logic [3:0] len_in = '0;
    logic [3:0] div_in = '0;
    logic       busy, irq, dev_valid;
    logic       irq_ack = 1'b0;
    logic       dev_ready = 1'b0;
    logic [7:0] dev_data;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_out_ctrl #(
        .DATA_W(8), .DEPTH(DEPTH), .DIV_W(DIV_W), .AW(AW), .LEN_W(LEN_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .len_in(len_in), .div_in(div_in),
        .busy(busy), .irq(irq), .irq_ack(irq_ack), .dev_data(dev_data),
        .dev_valid(dev_valid), .dev_ready(dev_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run(input int len, input int dv, input int rmode,
                       input bit ack_last, input bit poke);
        int n_exp;
        int fires;
        int last_fire;
        int c;
        int limit;
        bit poked;
        bit stalled;
        logic [7:0] stall_data;
        n_exp = (len > DEPTH) ? DEPTH : len;
        fires = 0;
        last_fire = -1;
        poked = 1'b0;
        stalled = 1'b0;
        stall_data = '0;
        limit = (n_exp + 1) * (dv + 1) * 3 + 20;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = i[2:0];
            wr_data = 8'(len * 16 + dv * 4 + i * 7 + 3);
            exp_mem[i] = wr_data;
        end
        @(negedge clk);
        wr_en = 1'b0;
        start = 1'b1;
        len_in = len[3:0];
        div_in = dv[3:0];
        @(negedge clk);
        start = 1'b0;
        c = 1;
        if (n_exp == 0) begin
            dev_ready = 1'b1;
            #1;
            chk(irq === 1'b1, "R10 irq", int'(irq), 1);
            chk(busy === 1'b0, "R10 busy", int'(busy), 0);
            for (int k = 0; k < 3; k++) begin
                chk(dev_valid === 1'b0, "R10 nothing sent", int'(dev_valid), 0);
                @(negedge clk);
                #1;
            end
        end else begin
            while (fires < n_exp && c < limit) begin
                wr_en = 1'b0;
                start = 1'b0;
                irq_ack = 1'b0;
                dev_ready = (rmode == 0) ? 1'b1 : ((c % 3) != 1);
                if (poke && fires == 1 && !poked) begin
                    poked = 1'b1;
                    wr_en = 1'b1;
                    wr_addr = 3'd2;
                    wr_data = 8'hEE;
                    start = 1'b1;
                    len_in = 4'd1;
                end
                #1;
                chk(irq === 1'b0, "R7 irq early", int'(irq), 0);
                if (c == 1) begin
                    chk(busy === 1'b1, "R3 busy", int'(busy), 1);
                    chk(dev_valid === 1'b1, "R3 first offer", int'(dev_valid), 1);
                end
                if (stalled) begin
                    chk(dev_valid === 1'b1, "R5 valid held", int'(dev_valid), 1);
                    chk(dev_data === stall_data, "R5 data held", int'(dev_data), int'(stall_data));
                end
                stalled = dev_valid && !dev_ready;
                stall_data = dev_data;
                if (dev_valid && dev_ready) begin
                    chk(dev_data === exp_mem[fires], poke ? "R6 data" : "R2 data",
                        int'(dev_data), int'(exp_mem[fires]));
                    if (fires > 0) begin
                        if (rmode == 0)
                            chk(c - last_fire == dv + 1, "R4 spacing", c - last_fire, dv + 1);
                        else
                            chk(c - last_fire >= dv + 1, "R4 min spacing", c - last_fire, dv + 1);
                    end
                    last_fire = c;
                    fires++;
                    if (fires == n_exp && ack_last) irq_ack = 1'b1;
                end
                @(negedge clk);
                c++;
            end
            wr_en = 1'b0;
            start = 1'b0;
            chk(fires == n_exp, "R3 count", fires, n_exp);
            #1;
            chk(irq === 1'b1, ack_last ? "R9 set wins" : "R7 irq", int'(irq), 1);
            chk(busy === 1'b0, "R7 busy", int'(busy), 0);
            chk(dev_valid === 1'b0, "R7 valid", int'(dev_valid), 0);
            irq_ack = 1'b0;
        end
        @(negedge clk);
        #1;
        chk(irq === 1'b1, "R8 held", int'(irq), 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
        chk(irq === 1'b0, "R8 cleared", int'(irq), 0);
        chk(busy === 1'b0, "R6 no extra run", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(irq === 1'b0, "R1 irq", int'(irq), 0);
        chk(dev_valid === 1'b0, "R1 valid", int'(dev_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 4; d++)
                for (int l = 0; l <= DEPTH; l++)
                    run(l, d, m, 1'b0, 1'b0);
        run(12, 1, 0, 1'b0, 1'b0);
        run(15, 0, 1, 1'b0, 1'b0);
        run(2, 0, 0, 1'b1, 1'b0);
        run(3, 2, 1, 1'b1, 1'b0);
        run(4, 3, 0, 1'b0, 1'b1);
        run(6, 1, 1, 1'b0, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule